// File: doc/BRIEF.md
# IrDA Pulse-to-UART Line Decoder

This block turns an infrared serial pulse stream back into an ordinary UART-format receive line. In the pulse format, a zero bit is a short high pulse inside its bit slot and a one bit leaves the line low. Each high-to-low transition of the incoming line therefore marks the end of a zero bit. The decoder answers each such transition by pulling its output low and starting a timer one bit period long. The output goes back high only when a full bit period passes with no further transition. A run of zero bits keeps restarting the timer, so the output stays low across the whole run.

The incoming line first passes through a synchronizer. A one-cycle falling-edge pulse is then taken from the synchronized level. A two-state machine with a down-counter forms the retriggerable one-shot. Its states are IDLE and HOLD, and it has four named transitions. Arm (IDLE to HOLD) happens on an edge. Retrigger (HOLD to HOLD) reloads the counter on an edge. Count (HOLD to HOLD) decrements the counter. Expire (HOLD to IDLE) happens when the counter is zero and no edge is present. The output is high exactly in IDLE. The bit period in clock cycles is the clock frequency divided by the baud rate, rounded to the nearest integer. Both values are parameters.

Top module: `irda_rx_decoder`

## Requirements
- R1: A cycle with `rst` high forces `uart_rx` high and the timer idle at the next clock edge. An edge seen before or during reset does not resume the low level after reset is released.
- R2: While no falling edge of `irda_rx` has arrived within the last bit period, `uart_rx` is high.
- R3: A high-to-low change of `irda_rx` between two clock samples drives `uart_rx` low on the third rising clock edge after the change: two synchronizer flops, then the state register. The output is still high after the second edge.
- R4: After a single falling edge, `uart_rx` stays low for exactly BIT_CYCLES clock cycles and then returns high on its own. BIT_CYCLES = (CLK_HZ + BAUD/2) / BAUD, and BAUD defaults to 115200.
- R5: A falling edge that arrives while the timer runs restarts the count. `uart_rx` stays low until BIT_CYCLES cycles after the latest edge's arm point.
- R6: If a falling edge is detected in the same cycle that the count reaches its end, the restart wins and `uart_rx` stays low without a high glitch.
- R7: Rising edges of `irda_rx`, and a steady high level of any length, have no effect on `uart_rx`.
- R8: Feed the decoder with pulse-encoded data from a serial line. Each zero bit becomes a high pulse filling the last 3/16 of its slot, and each one bit becomes a low slot. The decoded `uart_rx` then equals the source serial line delayed by BIT_CYCLES + 3 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| irda_rx | input | 1 | Asynchronous infrared pulse line, low when idle |
| uart_rx | output | 1 | Recovered UART-format line, high when idle |

## Verification
The bench builds the decoder with CLK_HZ = 1,600,000 and BAUD = 100,000, which gives a 16-cycle bit period and a 3-cycle pulse. A whole frame then takes only a few hundred cycles, so many frames and every directed corner case fit in a short run. With this period, consecutive zero bits produce an edge exactly on the cycle the count ends. Normal pulse traffic therefore exercises the restart-versus-expiry collision, alongside a directed test of the same case. The small period also makes the exact low-time and latency cycles easy to count against the requirement model.

// File: rtl/irda_dec_pkg.sv
package irda_dec_pkg;

    // IDLE: line released high, HOLD: one-shot running, line low
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } dec_state_t;

    // Bit period in clock cycles, rounded to nearest
    function automatic int unsigned bit_cycles(input int unsigned clk_hz,
                                               input int unsigned baud);
        return (clk_hz + baud / 2) / baud;
    endfunction

endpackage

// File: rtl/irda_dec_sync.sv
module irda_dec_sync #(
    parameter int   STAGES    = 2,
    parameter logic RST_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] stage_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) stage_q <= RST_LEVEL;
                else     stage_q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stage_q <= {STAGES{RST_LEVEL}};
                else     stage_q <= {stage_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/irda_dec_edge.sv
module irda_dec_edge #(
    parameter logic RST_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic fall
);

    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RST_LEVEL;
        else     prev_q <= level;
    end

    // one-cycle pulse on a high-to-low change of the synchronized level
    assign fall = prev_q & ~level;

endmodule

// File: rtl/irda_dec_oneshot.sv
module irda_dec_oneshot
    import irda_dec_pkg::*;
#(
    parameter int unsigned BIT_CYCLES = 16,
    parameter int          CNT_W      = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig,
    output logic             line,
    output logic             busy,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] LOAD = CNT_W'(BIT_CYCLES - 1);

    dec_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // next-state: arm, retrigger, count, expire
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (trig) begin
                    state_d = ST_HOLD;         // arm
                    cnt_d   = LOAD;
                end
            end
            ST_HOLD: begin
                if (trig) begin
                    cnt_d = LOAD;              // retrigger
                end else if (cnt_q == '0) begin
                    state_d = ST_IDLE;         // expire
                end else begin
                    cnt_d = cnt_q - 1'b1;      // count
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs from state
    always_comb begin
        unique case (state_q)
            ST_IDLE: begin line = 1'b1; busy = 1'b0; end
            ST_HOLD: begin line = 1'b0; busy = 1'b1; end
        endcase
        cnt = cnt_q;
    end

endmodule

// File: rtl/irda_rx_decoder.sv
module irda_rx_decoder #(
    parameter int unsigned CLK_HZ      = 50_000_000,
    parameter int unsigned BAUD        = 115_200,
    parameter int          SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic irda_rx,
    output logic uart_rx
);

    localparam int unsigned BIT_CYCLES = irda_dec_pkg::bit_cycles(CLK_HZ, BAUD);
    localparam int          CNT_W      = (BIT_CYCLES > 2) ? $clog2(BIT_CYCLES) : 1;

    logic             sync_w;
    logic             fall_w;
    logic             busy_w;
    logic [CNT_W-1:0] cnt_w;

    irda_dec_sync #(
        .STAGES    (SYNC_STAGES),
        .RST_LEVEL (1'b0)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (irda_rx),
        .dout (sync_w)
    );

    irda_dec_edge #(
        .RST_LEVEL (1'b0)
    ) u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (sync_w),
        .fall  (fall_w)
    );

    irda_dec_oneshot #(
        .BIT_CYCLES (BIT_CYCLES),
        .CNT_W      (CNT_W)
    ) u_shot (
        .clk  (clk),
        .rst  (rst),
        .trig (fall_w),
        .line (uart_rx),
        .busy (busy_w),
        .cnt  (cnt_w)
    );

endmodule

// File: rtl/irda_dec_checker.sv
module irda_dec_checker #(
    parameter int unsigned BIT_CYCLES = 16,
    parameter int          CNT_W      = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             uart_rx,
    input logic             fall,
    input logic             busy,
    input logic [CNT_W-1:0] cnt
);

    AST_RESET_RELEASES_LINE: assert property (@(posedge clk)
        rst |=> (uart_rx && !busy)); // R1

    AST_LOW_ONLY_AFTER_EDGE: assert property (@(posedge clk) disable iff (rst)
        $fell(uart_rx) |-> $past(fall)); // R2

    AST_EDGE_ARMS_LOW: assert property (@(posedge clk) disable iff (rst)
        fall |=> !uart_rx); // R3

    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt <= CNT_W'(BIT_CYCLES - 1))); // R4

    AST_EXPIRY_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt == '0 && !fall) |=> uart_rx); // R4

    AST_HOLD_WHILE_COUNTING: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != '0) |=> !uart_rx); // R5

    AST_RESTART_BEATS_EXPIRY: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt == '0 && fall) |=> (!uart_rx && cnt == CNT_W'(BIT_CYCLES - 1))); // R6

endmodule

bind irda_rx_decoder irda_dec_checker #(
    .BIT_CYCLES (BIT_CYCLES),
    .CNT_W      (CNT_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .uart_rx (uart_rx),
    .fall    (fall_w),
    .busy    (busy_w),
    .cnt     (cnt_w)
);

// File: tb/irda_rx_decoder_test.sv
`timescale 1ns/1ps
module irda_rx_decoder_test;

    localparam int unsigned T_CLK_HZ = 1_600_000;
    localparam int unsigned T_BAUD   = 100_000;
    localparam int          N        = 16;     // bit period in cycles
    localparam int          D        = N + 3;  // chain delay, R8
    localparam int          NVEC     = 6;

    // stimulus byte / expected decoded byte
    localparam logic [15:0] VECS [NVEC] = '{
        16'h00_00, 16'hFF_FF, 16'h55_55, 16'hA5_A5, 16'h0F_0F, 16'h80_80
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic irda_rx = 1'b0;
    logic uart_rx;

    int   checks = 0;
    int   fails  = 0;
    int   cyc    = 0;
    logic done   = 1'b0;

    logic [63:0] fall_h  = '0;
    logic [63:0] orig_h  = '1;
    logic        prev_in = 1'b0;
    logic        chain_on = 1'b0;

    irda_rx_decoder #(
        .CLK_HZ (T_CLK_HZ),
        .BAUD   (T_BAUD)
    ) uut (
        .clk     (clk),
        .rst     (rst),
        .irda_rx (irda_rx),
        .uart_rx (uart_rx)
    );

    always #2 clk = ~clk;

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: uart_rx=%b expected %b (t=%0t)", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 30000 && !done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual cycles=%0d expected <30000", cyc);
            summary();
        end
    end

    // one cycle: drive after the edge, check before the next edge
    task automatic step(input logic v, input logic o);
        @(posedge clk);
        #1;
        irda_rx = v;
        fall_h  = {fall_h[62:0], prev_in & ~v};
        prev_in = v;
        orig_h  = {orig_h[62:0], o};
        @(negedge clk);
        // low exactly for cycles 3..N+2 after the latest edge (R2 R3 R4 R5 R6 R7)
        check(uart_rx, ~(|fall_h[N+2:3]), "R2 R4 R5 model");
        if (chain_on) check(uart_rx, orig_h[D], "R8 delayed source");
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst = 1'b1;
        irda_rx = 1'b0;
        prev_in = 1'b0;
        @(posedge clk);
        #1;
        rst = 1'b0;
        fall_h = '0;
        orig_h = '1;
        @(negedge clk);
        check(uart_rx, 1'b1, "R1 reset high");
    endtask

    task automatic send_frame(input logic [7:0] d, output logic [9:0] got);
        logic [9:0] bits;
        bits = {1'b1, d, 1'b0};
        got  = '1;
        for (int b = 0; b <= 10; b++) begin
            for (int c = 0; c < N; c++) begin
                logic o;
                o = (b < 10) ? bits[b] : 1'b1;
                step(!o && (c >= N - 3), o);
                if (b >= 1 && c == N / 2) got[b-1] = uart_rx;
            end
        end
    endtask

    initial begin
        logic [9:0] got;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(uart_rx, 1'b1, "R1 after power-on reset");

        // R2: idle line
        repeat (2 * N) step(1'b0, 1'b1);

        // R3 R4: single pulse
        step(1'b1, 1'b1); step(1'b1, 1'b1); step(1'b1, 1'b1);
        step(1'b0, 1'b1);
        for (int k = 1; k <= N + 4; k++) begin
            step(1'b0, 1'b1);
            if (k == 2)     check(uart_rx, 1'b1, "R3 still high after two edges");
            if (k == 3)     check(uart_rx, 1'b0, "R3 low on third edge");
            if (k == N + 2) check(uart_rx, 1'b0, "R4 last low cycle");
            if (k == N + 3) check(uart_rx, 1'b1, "R4 expiry high");
        end

        // R5: retrigger six cycles after the first edge
        step(1'b1, 1'b1); step(1'b0, 1'b1);
        for (int k = 1; k <= 2 * N + 8; k++) begin
            step((k == 4 || k == 5), 1'b1);
            if (k == N + 3)     check(uart_rx, 1'b0, "R5 extended past first window");
            if (k == N + 8)     check(uart_rx, 1'b0, "R5 last low cycle");
            if (k == N + 9)     check(uart_rx, 1'b1, "R5 release");
        end

        // R6: second edge lands exactly at expiry
        step(1'b1, 1'b1); step(1'b0, 1'b1);
        for (int k = 1; k <= 2 * N + 6; k++) begin
            step((k == N - 1), 1'b1);
            if (k == N + 3)     check(uart_rx, 1'b0, "R6 restart wins over expiry");
            if (k == 2 * N + 3) check(uart_rx, 1'b1, "R6 release");
        end

        // R7: long high level, rising edge only
        for (int k = 0; k < 3 * N; k++) step(1'b1, 1'b1);
        check(uart_rx, 1'b1, "R7 high level ignored");
        repeat (N + 4) step(1'b0, 1'b1);

        // R1: reset in the middle of a low window
        step(1'b1, 1'b1); step(1'b0, 1'b1);
        repeat (4) step(1'b0, 1'b1);
        check(uart_rx, 1'b0, "R1 precondition low");
        do_reset();
        for (int k = 0; k < N + 4; k++) step(1'b0, 1'b1);
        check(uart_rx, 1'b1, "R1 no resume after reset");

        // R8: encoded frames through the decoder, table walk
        chain_on = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            send_frame(VECS[i][15:8], got);
            checks++;
            if (got[8:1] !== VECS[i][7:0] || got[0] !== 1'b0 || got[9] !== 1'b1) begin
                fails++;
                $display("FAIL R8 frame %0d: decoded=%h expected=%h", i, got, {1'b1, VECS[i][7:0], 1'b0});
            end
            repeat (N) step(1'b0, 1'b1);
        end
        chain_on = 1'b0;

        done = 1'b1;
        summary();
    end

endmodule